// File: doc/BRIEF.md
# Serial SAR ADC Read Controller

This block is the host-side master for a serial successive-approximation converter that is read over a chip-select line, a serial clock and a single data line. It runs on a fast system clock and makes the serial clock by holding each SCLK half-period for a programmable number of system cycles. A read frame begins when the controller pulls chip-select low. That edge also makes the converter take its sample and start converting, so each frame returns the result of its own sample.

In a frame the converter first sends four zero bits and then the result, most significant bit first. The frame length follows the resolution: 12, 14 or 16 SCLK cycles for 8, 10 or 12 result bits. The controller samples the data line at every SCLK falling edge. It drops the leading zeros and delivers the result right-justified, with a one-cycle valid strobe. After the last falling edge it releases the bus and keeps chip-select high for a quiet gap before the next frame can begin.

A frame is started by a single start pulse, or repeatedly while a run level is held high. A start pulse that arrives while a frame or a quiet gap is in progress is remembered and served once the gap ends. A sticky error flag records any leading-zero position that was read as a one.

Top module: `sar_adc_reader`

## Requirements
- R1: While reset is active and after it is released, chip-select and SCLK are high, valid is low, the data word is zero and the error flag is low.
- R2: A frame starts when start_i is high, when a held start request is pending, or while run_i is high. Chip-select then stays low for exactly 2·N·H system cycles. H is div_i, or 1 when div_i is 0. N is the frame length: 12 when res_i is 0, 14 when res_i is 1, and 16 when res_i is 2 or 3.
- R3: SCLK is high whenever chip-select is high. A frame has exactly N SCLK falling edges. The first falling edge comes H cycles after chip-select falls, and every low and high phase lasts H cycles. SCLK is back high when chip-select rises.
- R4: The data line is sampled at each SCLK falling edge. The last R bits sampled form data_o, MSB first in straight binary (all ones is full scale), zero-extended to 12 bits. R is 8, 10 or 12 for res_i 0, 1 or 2/3.
- R5: valid_o is high for exactly one cycle per frame, in the first cycle in which chip-select is high again. data_o holds its value until the next valid.
- R6: Between frames chip-select stays high for at least QUIET_CYC system cycles. With run_i held high, or with a request waiting, the gap is exactly QUIET_CYC cycles.
- R7: A start pulse seen during a frame or a quiet gap is held. It launches exactly one further frame, as soon as the gap ends.
- R8: If any of the first four bits of a frame is sampled as one, frame_err_o goes high and stays high until reset. That frame's data is still delivered.
- R9: div_i and res_i are captured when a frame starts. Changing them during the frame has no effect on its timing or its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one frame |
| run_i | input | 1 | Start frames back to back while high |
| div_i | input | DIV_W | SCLK half-period in system cycles (0 is treated as 1) |
| res_i | input | 2 | Resolution select: 0 = 8 bits, 1 = 10 bits, 2 or 3 = 12 bits |
| adc_sdata_i | input | 1 | Serial data from the converter |
| adc_cs_n_o | output | 1 | Active-low chip-select; its falling edge starts the conversion |
| adc_sclk_o | output | 1 | Serial clock, high when idle |
| data_o | output | 12 | Right-justified conversion result |
| valid_o | output | 1 | One-cycle strobe when data_o is updated |
| frame_err_o | output | 1 | Sticky flag set when a leading zero reads as one |

## Verification
Chip-select falls at the clock edge after a request is seen. SCLK falls H cycles later and then toggles every H cycles. Chip-select rises and valid appears together, 2·N·H cycles after the fall, and the next fall comes exactly QUIET_CYC cycles after that when a request is waiting. The bench samples every output on the falling system-clock edge and measures low time, gap length, phase widths and falling-edge counts with its own counters. It compares those counts against the formulas above, which it works out from the settings it applied, and it waits for a valid count rather than for a fixed delay. A converter model in the bench drives each bit on the chip-select and SCLK falling edges, so every data check depends on the controller sampling at the right edge.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned CNT_W  = 5;
  localparam logic [CNT_W-1:0] LEAD_ZEROS = 5'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_QUIET
  } seq_t;

  // result width chosen by the resolution select
  function automatic logic [CNT_W-1:0] res_len(input logic [1:0] sel);
    case (sel)
      2'd0:    res_len = 5'd8;
      2'd1:    res_len = 5'd10;
      default: res_len = 5'd12;
    endcase
  endfunction

  // SCLK cycles per frame: leading zeros plus result bits
  function automatic logic [CNT_W-1:0] frame_len(input logic [1:0] sel);
    frame_len = res_len(sel) + LEAD_ZEROS;
  endfunction

  // keeps only the result bits of the shift register
  function automatic logic [DATA_W-1:0] res_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    res_mask = 12'h0FF;
      2'd1:    res_mask = 12'h3FF;
      default: res_mask = 12'hFFF;
    endcase
  endfunction
endpackage

// File: rtl/sar_half_timer.sv
module sar_half_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic [W-1:0] half_i,
  output logic         tick_o
);
  logic [W-1:0] cnt;
  logic [W-1:0] half_eff;

  assign half_eff = (half_i == '0) ? W'(1) : half_i;
  assign tick_o   = (cnt == '0) && !restart_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart_i || cnt == '0)
      cnt <= half_eff - W'(1);
    else
      cnt <= cnt - W'(1);
  end

  // R3: a restart always leaves the counter inside the half-period
  p_reload_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart_i) |-> (cnt < half_eff || $past(half_i) != half_i));
endmodule

// File: rtl/sar_deser.sv
module sar_deser
  import sar_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic              bit_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic [1:0]        res_i,
  output logic [DATA_W-1:0] word_o,
  output logic              lead_one_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;

  assign cnt_o      = cnt;
  assign word_o     = sr & res_mask(res_i);
  assign lead_one_o = cap_i && bit_i && (cnt < LEAD_ZEROS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clear_i) begin
      sr  <= '0;
      cnt <= '0;
    end else if (cap_i) begin
      sr  <= {sr[DATA_W-2:0], bit_i};
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R3: never more captures than the frame has falling edges
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= nbits_i);
endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
  import sar_rd_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int QUIET_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [1:0]        res_i,
  input  logic              adc_sdata_i,
  output logic              adc_cs_n_o,
  output logic              adc_sclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  localparam int Q_W = $clog2(QUIET_CYC + 1);

  seq_t              state;
  logic              cs_n_q, sclk_q, valid_q, err_q, pend_q;
  logic [DIV_W-1:0]  div_q;
  logic [1:0]        res_q;
  logic [Q_W-1:0]    qcnt;
  logic [DATA_W-1:0] data_q;

  // named internal events
  logic              tick, req, can_go, launch, cap_ev, last_ev, lead_one;
  logic [CNT_W-1:0]  bit_cnt, nbits;
  logic [DATA_W-1:0] word;
  logic [DIV_W-1:0]  half_sel;

  assign nbits    = frame_len(res_q);
  assign req      = start_i || pend_q || run_i;
  assign can_go   = (state == ST_IDLE) || (state == ST_QUIET && qcnt == '0);
  assign launch   = can_go && req;
  assign cap_ev   = tick && (state == ST_SETUP || state == ST_HIGH);
  assign last_ev  = tick && (state == ST_LOW) && (bit_cnt == nbits);
  assign half_sel = launch ? div_i : div_q;

  sar_half_timer #(.W(DIV_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (launch),
    .half_i    (half_sel),
    .tick_o    (tick)
  );

  sar_deser u_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (launch),
    .cap_i      (cap_ev),
    .bit_i      (adc_sdata_i),
    .nbits_i    (nbits),
    .res_i      (res_q),
    .word_o     (word),
    .lead_one_o (lead_one),
    .cnt_o      (bit_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      pend_q  <= 1'b0;
      div_q   <= '0;
      res_q   <= 2'd2;
      qcnt    <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= err_q || lead_one;
      if (launch)
        pend_q <= 1'b0;
      else if (start_i)
        pend_q <= 1'b1;
      unique case (state)
        ST_IDLE, ST_QUIET: begin
          if (launch) begin
            state  <= ST_SETUP;
            cs_n_q <= 1'b0;
            div_q  <= div_i;
            res_q  <= res_i;
          end else if (state == ST_QUIET) begin
            if (qcnt == '0) state <= ST_IDLE;
            else            qcnt  <= qcnt - Q_W'(1);
          end
        end
        ST_SETUP, ST_HIGH: begin
          if (tick) begin
            sclk_q <= 1'b0;
            state  <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            sclk_q <= 1'b1;
            if (last_ev) begin
              cs_n_q  <= 1'b1;
              valid_q <= 1'b1;
              data_q  <= word;
              qcnt    <= Q_W'(QUIET_CYC - 1);
              state   <= ST_QUIET;
            end else begin
              state <= ST_HIGH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign adc_cs_n_o  = cs_n_q;
  assign adc_sclk_o  = sclk_q;
  assign data_o      = data_q;
  assign valid_o     = valid_q;
  assign frame_err_o = err_q;

  // checker state: length of the current chip-select high run
  logic [Q_W-1:0] hi_run;
  logic           seen_frame;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run     <= '0;
      seen_frame <= 1'b0;
    end else begin
      if (valid_q) seen_frame <= 1'b1;
      if (!cs_n_q)
        hi_run <= '0;
      else if (hi_run < Q_W'(QUIET_CYC))
        hi_run <= hi_run + Q_W'(1);
    end
  end

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> sclk_q);
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  p_valid_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $rose(cs_n_q));
  p_quiet_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_frame && $fell(cs_n_q)) |-> (hi_run >= Q_W'(QUIET_CYC)));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_q && $past(!cs_n_q)) |-> ($stable(div_q) && $stable(res_q)));
endmodule

// File: tb/sim_sar_adc_reader.sv
module sim_sar_adc_reader;
  localparam int QC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        run = 1'b0;
  logic [7:0]  div = 8'd2;
  logic [1:0]  res = 2'd2;
  logic        sdata = 1'b0;
  logic        cs_n, sclk, valid, ferr;
  logic [11:0] data;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  sar_adc_reader #(.DIV_W(8), .QUIET_CYC(QC)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .run_i(run),
    .div_i(div), .res_i(res), .adc_sdata_i(sdata),
    .adc_cs_n_o(cs_n), .adc_sclk_o(sclk), .data_o(data),
    .valid_o(valid), .frame_err_o(ferr)
  );

  // converter model: first bit on chip-select fall, next on each SCLK fall
  logic [15:0] mdl_bits = '0;
  int          mdl_idx = 0;
  always @(negedge cs_n) begin
    mdl_idx = 0;
    sdata   = mdl_bits[0];
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      mdl_idx = mdl_idx + 1;
      sdata   = (mdl_idx < 16) ? mdl_bits[mdl_idx] : 1'b0;
    end
  end

  // port monitor, sampled on the falling system-clock edge
  int   low_cnt = 0, last_low = 0, hi_cnt = 0, last_gap = 0;
  int   fall_cnt = 0, last_falls = 0, ph = 0, ph_min = 999, ph_max = 0;
  int   vcount = 0, bad_valid = 0, hi_sclk_bad = 0;
  logic [11:0] vdata = '0;
  logic p_cs = 1'b1, p_sclk = 1'b1, p_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n && !sclk) hi_sclk_bad++;
      if (!cs_n) low_cnt++; else hi_cnt++;
      if (p_cs && !cs_n) begin last_gap = hi_cnt; hi_cnt = 0; fall_cnt = 0; end
      if (!p_cs && cs_n) begin last_low = low_cnt; low_cnt = 0; last_falls = fall_cnt; hi_cnt = 1; end
      if (!cs_n && p_sclk && !sclk) fall_cnt++;
      if (sclk != p_sclk || cs_n != p_cs) begin
        if (!p_cs && sclk != p_sclk) begin
          if (ph < ph_min) ph_min = ph;
          if (ph > ph_max) ph_max = ph;
        end
        ph = 1;
      end else ph++;
      if (valid) begin
        vcount++;
        vdata = data;
        if (p_valid || !cs_n || p_cs) bad_valid++;
      end
      p_cs = cs_n; p_sclk = sclk; p_valid = valid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int flen(input logic [1:0] r);
    return (r == 2'd0) ? 12 : (r == 2'd1) ? 14 : 16;
  endfunction

  function automatic int hlen(input logic [7:0] d);
    return (d == 8'd0) ? 1 : int'(d);
  endfunction

  task automatic load_model(input logic [1:0] r, input logic [11:0] code, input bit bad_lead);
    int n = flen(r);
    int rb = n - 4;
    for (int i = 0; i < 16; i++) begin
      if (i < 4)      mdl_bits[i] = bad_lead && (i == 1);
      else if (i < n) mdl_bits[i] = code[rb - 1 - (i - 4)];
      else            mdl_bits[i] = 1'b0;
    end
  endtask

  task automatic wait_valid(input int target);
    int k = 0;
    while (vcount < target && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // one frame with given settings; checks length, edges, phases and data
  task automatic t_frame(input logic [1:0] r, input logic [7:0] d,
                         input logic [11:0] code, input string tag);
    int target = vcount + 1;
    int n = flen(r);
    int h = hlen(d);
    logic [11:0] exp_d = code & ((r == 2'd0) ? 12'h0FF : (r == 2'd1) ? 12'h3FF : 12'hFFF);
    load_model(r, code, 1'b0);
    res = r; div = d;
    ph_min = 999; ph_max = 0; bad_valid = 0;
    pulse_start();
    wait_valid(target);
    check(vcount == target, {tag, " R5 valid count"}, vcount, target);
    check(last_low == 2 * n * h, {tag, " R2 cs low length"}, last_low, 2 * n * h);
    check(last_falls == n, {tag, " R3 falling edges"}, last_falls, n);
    check(ph_min == h && ph_max == h, {tag, " R3 phase width"}, ph_max, h);
    check(vdata == exp_d, {tag, " R4 data"}, int'(vdata), int'(exp_d));
    check(bad_valid == 0, {tag, " R5 valid pulse shape"}, bad_valid, 0);
    repeat (6) @(negedge clk);
    check(data == exp_d, {tag, " R5 data held"}, int'(data), int'(exp_d));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(cs_n && sclk && !valid && data == 0 && !ferr, "R1 reset state",
          int'({cs_n, sclk, valid, ferr}), 4'b1100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n && sclk && !valid && !ferr, "R1 idle after reset",
          int'({cs_n, sclk, valid, ferr}), 4'b1100);
  endtask

  task automatic t_cfg_change();
    int target = vcount + 1;
    load_model(2'd2, 12'h5A3, 1'b0);
    res = 2'd2; div = 8'd2;
    pulse_start();
    repeat (10) @(negedge clk);
    div = 8'd5; res = 2'd0;
    wait_valid(target);
    check(last_low == 2 * 16 * 2, "R9 length unaffected", last_low, 64);
    check(vdata == 12'h5A3, "R9 data unaffected", int'(vdata), 'h5A3);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_held_start();
    int base = vcount;
    load_model(2'd1, 12'h2C7, 1'b0);
    res = 2'd1; div = 8'd2;
    pulse_start();
    repeat (8) @(negedge clk);
    pulse_start();
    wait_valid(base + 2);
    check(vcount == base + 2, "R7 held start served", vcount, base + 2);
    check(last_gap == QC, "R6 gap after held start", last_gap, QC);
    // a start in the quiet gap
    pulse_start();
    wait_valid(base + 3);
    check(last_gap == QC, "R7 start in quiet gap", last_gap, QC);
    repeat (80) @(negedge clk);
    check(vcount == base + 3, "R7 exactly one frame per request", vcount, base + 3);
  endtask

  task automatic t_run_mode();
    int base = vcount;
    load_model(2'd0, 12'h0C3, 1'b0);
    res = 2'd0; div = 8'd1;
    @(negedge clk) run = 1'b1;
    wait_valid(base + 3);
    check(last_gap == QC, "R6 run mode gap", last_gap, QC);
    check(vdata == 12'h0C3, "R2 run mode data", int'(vdata), 'h0C3);
    @(negedge clk) run = 1'b0;
    repeat (60) @(negedge clk);
    check(cs_n == 1'b1, "R2 run released", int'(cs_n), 1);
    check(hi_sclk_bad == 0, "R3 SCLK high while deselected", hi_sclk_bad, 0);
  endtask

  task automatic t_lead_error();
    int target = vcount + 1;
    check(ferr == 1'b0, "R8 clean before", int'(ferr), 0);
    load_model(2'd2, 12'h812, 1'b1);
    res = 2'd2; div = 8'd2;
    pulse_start();
    wait_valid(target);
    @(negedge clk);
    check(ferr == 1'b1, "R8 error raised", int'(ferr), 1);
    check(vdata == 12'h812, "R8 data still delivered", int'(vdata), 'h812);
    load_model(2'd2, 12'h001, 1'b0);
    pulse_start();
    wait_valid(target + 1);
    @(negedge clk);
    check(ferr == 1'b1, "R8 error sticky", int'(ferr), 1);
  endtask

  initial begin
    #(200000 * 20);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_frame(2'd2, 8'd2, 12'hA5C, "12b");
    t_frame(2'd1, 8'd3, 12'h3FF, "10b full scale");
    t_frame(2'd0, 8'd1, 12'h000, "8b zero");
    t_frame(2'd0, 8'd0, 12'h0B6, "div zero");
    t_frame(2'd3, 8'd2, 12'hFFF, "sel3 full scale");
    t_cfg_change();
    t_held_start();
    t_run_mode();
    t_lead_error();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule